// File: doc/BRIEF.md
# Camera Bring-Up Sequencer

This block takes an image sensor from power-up to a configured state. After the global reset is released it starts a divided reference clock for the sensor and keeps the sensor's active-low reset asserted for a fixed hold time. It then releases the sensor and waits a second fixed interval, because the sensor is not ready for configuration immediately after leaving reset. After that wait it asks an external serial control-bus master to read the sensor's product-ID register.

The configuration writes run only if the ID byte matches the expected value. In that case the sequencer walks an internal table of {register, value} pairs. Each pair becomes one write request to the master. A sentinel entry ends the table, and the sequencer then raises a ready flag. If the ID byte does not match, the sequencer raises a sticky mismatch flag and stops.

Each request stays on the request port until the master pulses its done strobe. If the master reports a bus error with done, the same transfer is requested again. The hold time and the wait time are given in microseconds and turned into cycle counts from the system clock frequency when the design is elaborated.

Top module: `cam_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `cam_rst_n`, `cam_refclk`, `req_valid`, `cfg_ready` and `id_bad` are all 0.
- R2: From reset release, `cam_refclk` toggles once every REF_HALF clock edges, where REF_HALF = max(1, CLK_HZ / (2*REF_HZ)). It runs during the sensor-reset hold.
- R3: `cam_rst_n` rises on exactly the HOLD_CYC-th clock edge after reset release, where HOLD_CYC = CLK_HZ/1e6 * HOLD_US. It then stays high until the next global reset.
- R4: The first request appears exactly WAIT_CYC = CLK_HZ/1e6 * WAIT_US edges after `cam_rst_n` rises. It is a read (`req_read`=1) with `req_dev` = {DEV_ID, 1} = 0x61, `req_addr` = 0x0A and `req_wdata` = 0. No request is made while `cam_rst_n` is low.
- R5: While `req_valid` is high and `bus_done` is low, the request stays up and all its fields stay unchanged. A transfer completes on the edge where `bus_done` is high.
- R6: If `bus_done` comes with `bus_err` high, the transfer does not advance, and the identical request stays up for another attempt.
- R7: If the ID read returns 0x26, a write request is issued for each table entry i = 0..CFG_LEN-1, in order. Each has `req_read`=0, `req_dev` = {DEV_ID, 0} = 0x60, `req_addr` = CFG_BASE+i and `req_wdata` = low byte of 0x11*(i+1). Entry CFG_LEN is the sentinel (register 0xFF), and no request is made for it.
- R8: `cfg_ready` rises on the second clock edge after the last write completes. After that it stays high, `req_valid` stays low, and `bus_done` has no effect.
- R9: If the ID read returns any value other than 0x26, `id_bad` rises on the completing edge and stays high. No write is requested and `cfg_ready` never rises.
- R10: A global reset at any point, including in the middle of the configuration writes or after a mismatch, re-asserts the sensor reset and clears both flags. The whole sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| cam_rst_n | output | 1 | Sensor reset, active low |
| cam_refclk | output | 1 | Divided reference clock for the sensor |
| req_valid | output | 1 | Transfer request to the control-bus master |
| req_read | output | 1 | 1 = read transfer, 0 = write transfer |
| req_dev | output | 8 | Device ID with the read/write flag in bit 0 |
| req_addr | output | 8 | Sensor register address |
| req_wdata | output | 8 | Write data (0 for reads) |
| bus_done | input | 1 | One-cycle completion strobe from the master |
| bus_rdata | input | 8 | Read data, valid with `bus_done` |
| bus_err | input | 1 | Bus error, valid with `bus_done` |
| cfg_ready | output | 1 | Configuration finished |
| id_bad | output | 1 | Sticky product-ID mismatch flag |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, so each 3 ms interval becomes 3000 cycles. This lets the exact hold and wait edge counts be measured more than once within a short run. REF_HZ = 250 kHz gives a half period of 2, so the reference-clock toggle count over the whole hold window can be compared with a non-trivial divider. CFG_LEN = 5 with CFG_BASE = 0x20 makes the table long enough for a global reset to land mid-way, after two of the writes. Random master latencies and injected bus errors then exercise request holding and retry on both the ID read and the writes.

// File: rtl/cam_bringup_seq.sv
module cam_bringup_seq #(
  parameter int          CLK_HZ   = 100_000_000,
  parameter int          HOLD_US  = 3000,
  parameter int          WAIT_US  = 3000,
  parameter int          REF_HZ   = 24_000_000,
  parameter int          CFG_LEN  = 4,
  parameter logic [7:0]  CFG_BASE = 8'h20,
  parameter logic [7:0]  ID_REG   = 8'h0A,
  parameter logic [7:0]  ID_VAL   = 8'h26,
  parameter logic [6:0]  DEV_ID   = 7'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       cam_rst_n,
  output logic       cam_refclk,
  output logic       req_valid,
  output logic       req_read,
  output logic [7:0] req_dev,
  output logic [7:0] req_addr,
  output logic [7:0] req_wdata,
  input  logic       bus_done,
  input  logic [7:0] bus_rdata,
  input  logic       bus_err,
  output logic       cfg_ready,
  output logic       id_bad
);
  localparam int HOLD_CYC = CLK_HZ / 1_000_000 * HOLD_US;
  localparam int WAIT_CYC = CLK_HZ / 1_000_000 * WAIT_US;
  localparam int DLY_MAX  = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int CW       = $clog2(DLY_MAX + 1);
  localparam int REF_RAW  = CLK_HZ / (2 * REF_HZ);
  localparam int REF_HALF = (REF_RAW < 1) ? 1 : REF_RAW;
  localparam int RW       = $clog2(REF_HALF + 1);
  localparam int IW       = $clog2(CFG_LEN + 1);

  typedef enum logic [2:0] {S_HOLD, S_WAIT, S_ID, S_CFG, S_READY, S_FAIL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refcnt;
  logic [IW-1:0] idx;
  logic          ref_q;

  function automatic logic [15:0] rom_entry(input logic [IW-1:0] i);
    if (int'(i) >= CFG_LEN) rom_entry = 16'hFFFF;
    else rom_entry = {8'(CFG_BASE + 8'(i)), 8'(8'h11 * (int'(i) + 1))};
  endfunction

  wire [15:0] ent  = rom_entry(idx);
  wire        last = (ent[15:8] == 8'hFF);
  wire        ok   = bus_done && !bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refcnt <= '0;
      ref_q  <= 1'b0;
    end else if (refcnt == RW'(REF_HALF - 1)) begin
      refcnt <= '0;
      ref_q  <= ~ref_q;
    end else begin
      refcnt <= refcnt + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_HOLD;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        S_HOLD:
          if (cnt == CW'(HOLD_CYC - 1)) begin
            state <= S_WAIT;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        S_WAIT:
          if (cnt == CW'(WAIT_CYC - 1)) begin
            state <= S_ID;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        S_ID:
          if (ok) begin
            state <= (bus_rdata == ID_VAL) ? S_CFG : S_FAIL;
            idx   <= '0;
          end
        S_CFG:
          if (last) state <= S_READY;
          else if (ok) idx <= idx + IW'(1);
        default: state <= state;
      endcase
    end
  end

  assign cam_rst_n  = (state != S_HOLD);
  assign cam_refclk = ref_q;
  assign req_read   = (state == S_ID);
  assign req_valid  = req_read || (state == S_CFG && !last);
  assign req_dev    = {DEV_ID, req_read};
  assign req_addr   = req_read ? ID_REG : ent[15:8];
  assign req_wdata  = req_read ? 8'h00 : ent[7:0];
  assign cfg_ready  = (state == S_READY);
  assign id_bad     = (state == S_FAIL);
endmodule

// File: rtl/cam_bringup_chk.sv
module cam_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cam_rst_n,
  input logic       req_valid,
  input logic       req_read,
  input logic [7:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       bus_done,
  input logic       bus_err,
  input logic       cfg_ready,
  input logic       id_bad
);
  AST_SENSOR_RST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cam_rst_n |=> cam_rst_n); // R3
  AST_NO_REQ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_rst_n |-> !req_valid); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_done |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_read)); // R5
  AST_ERR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bus_done && bus_err |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_read)); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready && !req_valid); // R8
  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    id_bad |=> id_bad && !cfg_ready && !req_valid); // R9
endmodule

bind cam_bringup_seq cam_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cam_rst_n(cam_rst_n), .req_valid(req_valid),
  .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
  .bus_done(bus_done), .bus_err(bus_err), .cfg_ready(cfg_ready), .id_bad(id_bad)
);

// File: tb/tb_cam_bringup_seq.sv
module tb_cam_bringup_seq;
  localparam int         CLK_HZ   = 1_000_000;
  localparam int         HOLD     = 3000;
  localparam int         WAITC    = 3000;
  localparam int         HALF     = 2;
  localparam int         CFG_LEN  = 5;
  localparam logic [7:0] CFG_BASE = 8'h20;

  logic clk = 0, rst_n = 0;
  logic cam_rst_n, cam_refclk, req_valid, req_read, cfg_ready, id_bad;
  logic [7:0] req_dev, req_addr, req_wdata;
  logic bus_done = 0, bus_err = 0;
  logic [7:0] bus_rdata = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  cam_bringup_seq #(.CLK_HZ(CLK_HZ), .HOLD_US(3000), .WAIT_US(3000), .REF_HZ(250_000),
                    .CFG_LEN(CFG_LEN), .CFG_BASE(CFG_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cam_rst_n(cam_rst_n), .cam_refclk(cam_refclk),
    .req_valid(req_valid), .req_read(req_read), .req_dev(req_dev), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cfg_ready(cfg_ready), .id_bad(id_bad));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(int i);
    return 8'(CFG_BASE + 8'(i));
  endfunction
  function automatic logic [7:0] exp_data(int i);
    return 8'(8'h11 * (i + 1));
  endfunction

  task automatic apply_reset(input string req);
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cam_rst_n && !cam_refclk && !req_valid, req, "outputs in reset",
        {cam_rst_n, cam_refclk, req_valid}, 0);
    chk(!cfg_ready && !id_bad, req, "flags in reset", {cfg_ready, id_bad}, 0);
    rst_n = 1;
  endtask

  task automatic run_to_id();
    bit prev = cam_refclk;
    int tog = 0;
    int n = 0;
    int m = 0;
    do begin
      @(negedge clk); n++;
      if (cam_refclk != prev) tog++;
      prev = cam_refclk;
    end while (!cam_rst_n && n < HOLD + 10);
    chk(n == HOLD, "R3", "edges to sensor reset release", n, HOLD);
    chk(tog == HOLD / HALF, "R2", "refclk toggles in hold", tog, HOLD / HALF);
    do begin
      @(negedge clk); m++;
    end while (!req_valid && m < WAITC + 10);
    chk(m == WAITC, "R4", "edges from release to first request", m, WAITC);
  endtask

  task automatic serve(input bit rd, input logic [7:0] addr, input logic [7:0] wd,
                       input logic [7:0] rdata, input bit force_err, input string req);
    bit got = 0;
    bit err;
    bit first = 1;
    for (int k = 0; k < 20 && !got; k++) begin
      if (req_valid) got = 1;
      else @(negedge clk);
    end
    chk(got, req, "request present", req_valid, 1);
    if (!got) return;
    chk(req_read == rd, req, "req_read", req_read, rd);
    chk(req_dev == {7'h30, rd}, req, "req_dev", req_dev, {7'h30, rd});
    chk(req_addr == addr, req, "req_addr", req_addr, addr);
    chk(req_wdata == wd, req, "req_wdata", req_wdata, wd);
    do begin
      int d = $urandom % 4;
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk(req_valid && req_addr == addr && req_wdata == wd && req_read == rd, "R5",
            "request held while waiting", {req_valid, req_addr}, {1'b1, addr});
      end
      err = (force_err && first) || ($urandom % 5 == 0);
      first = 0;
      bus_done = 1; bus_err = err;
      bus_rdata = err ? 8'($urandom) : rdata;
      @(negedge clk);
      bus_done = 0; bus_err = 0;
      if (err)
        chk(req_valid && req_addr == addr && req_wdata == wd && req_read == rd, "R6",
            "same request after bus error", {req_valid, req_addr}, {1'b1, addr});
    end while (err);
  endtask

  task automatic run_cfg(input int abort_at);
    for (int i = 0; i < CFG_LEN; i++) begin
      if (i == abort_at) return;
      serve(1'b0, exp_addr(i), exp_data(i), 8'h00, 1'b0, "R7");
    end
    chk(!req_valid && !cfg_ready, "R8", "no request and no ready one edge after last write",
        {req_valid, cfg_ready}, 0);
    @(negedge clk);
    chk(cfg_ready, "R8", "ready on second edge", cfg_ready, 1);
    for (int k = 0; k < 20; k++) begin
      bus_done = k[0];
      @(negedge clk);
    end
    bus_done = 0;
    chk(cfg_ready && !req_valid, "R8", "ready stays, no further request", {cfg_ready, req_valid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] bad;
    void'($urandom(32'd2024));
    apply_reset("R1");
    run_to_id();
    serve(1'b1, 8'h0A, 8'h00, 8'h26, 1'b1, "R4");
    run_cfg(-1);

    apply_reset("R10");
    run_to_id();
    bad = 8'($urandom);
    if (bad == 8'h26) bad = 8'h27;
    serve(1'b1, 8'h0A, 8'h00, bad, 1'b0, "R9");
    chk(id_bad && !req_valid && !cfg_ready, "R9", "mismatch flag set, bus quiet",
        {id_bad, req_valid, cfg_ready}, 3'b100);
    for (int k = 0; k < 30; k++) begin
      bus_done = k[0]; bus_rdata = 8'h26;
      @(negedge clk);
    end
    bus_done = 0;
    chk(id_bad && !req_valid && !cfg_ready, "R9", "mismatch sticky, no writes",
        {id_bad, req_valid, cfg_ready}, 3'b100);

    apply_reset("R10");
    run_to_id();
    serve(1'b1, 8'h0A, 8'h00, 8'h26, 1'b0, "R4");
    run_cfg(2);
    apply_reset("R10");
    run_to_id();
    serve(1'b1, 8'h0A, 8'h00, 8'h26, 1'b0, "R10");
    run_cfg(-1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule